// File: doc/BRIEF.md
# Integer Execute Unit with Condition Flag

This unit carries out the integer computations of a 32-bit RISC pipeline: arithmetic, bitwise logic, multiplication, shifts and rotates, comparisons, loading a constant into the upper half of a register, and division. The issuing stage presents one instruction word and two source operands together with `issue_valid`. The unit answers with a destination write (enable, register index, data), a single condition flag that only the compare instructions change, and a one-cycle trap pulse for encodings it cannot execute.

Every operation except division completes one cycle after it is accepted. Division is computed one quotient bit per clock by a restoring divider. `busy` stays high while it runs, and issue requests made during that time are not taken. A zero divisor raises the trap at once, and the divider is not started.

Instruction layout: class in bits 31:30, subclass in bits 29:26, destination index or compare selector in bits 25:21, 16-bit immediate in bits 15:0.

Top module: `int_exec_unit`

## Requirements
- R1: After reset `busy`, `done`, `wr_en`, `trap` and `flag` are all 0.
- R2: Register forms (class 3, subclass 8) pick the operation from bits 3:0: 0 add, 2 subtract, 3 and, 4 or, 5 xor, 6 multiply (low 32 bits). Each operates on `opa`,`opb` and gives `done`=1, `wr_en`=1, `wr_idx`=bits 25:21 and the result in the cycle after acceptance.
- R3: Immediate forms are class 2. Subclass 5 (add) and 7 (subtract) sign-extend bits 15:0. Subclasses 8 (and), 9 (or), 10 (xor) and 11 (multiply) zero-extend them.
- R4: Shifts use bits 7:5 as the kind: 0 logical left, 1 logical right, 2 arithmetic right, 4 rotate right. The register form is class 3, subclass 8, bits 3:0 = 8, with the amount in `opb[4:0]`. The immediate form is class 2, subclass 13, with the amount in bits 4:0.
- R5: Compares are class 3, subclass 9 against `opb`, or class 2, subclass 14 against the sign-extended immediate. Bits 25:21 select: 0 eq, 1 ne, 2..5 unsigned gt/ge/lt/le, 6..9 signed gt/ge/lt/le. The outcome goes to `flag` with `done`=1 and `wr_en`=0.
- R6: Class 0, subclass 6 writes bits 15:0 shifted left by 16 to the destination.
- R7: Class 3, subclass 8 with bits 3:0 = 9 (signed) or 10 (unsigned) divides `opa` by `opb`. `busy` rises in the cycle after acceptance. The quotient appears with `done`=1 and `wr_en` 32 cycles after acceptance, in the same cycle `busy` falls. The signed form truncates toward zero, and 0x80000000 / -1 gives 0x80000000.
- R8: A divide with `opb`=0 gives `trap`=1 and `done`=1 one cycle after acceptance, with `wr_en`=0 and `busy` staying 0.
- R9: An operation that targets register 0 completes with `done`=1 but `wr_en`=0.
- R10: Any other encoding, shift kind or compare selector above 9 gives `trap`=1 and `done`=1 one cycle later, with `wr_en`=0 and `flag` unchanged.
- R11: While `busy` is 1, `issue_valid` is ignored. A request still held when `busy` falls is accepted on the following edge.
- R12: Operations other than compares leave `flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Instruction presented this cycle |
| instr | input | 32 | Instruction word |
| opa | input | 32 | First source operand |
| opb | input | 32 | Second source operand |
| busy | output | 1 | Divider running, issue not taken |
| done | output | 1 | An accepted operation finished this cycle |
| wr_en | output | 1 | Destination write enable |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 32 | Destination write data |
| flag | output | 1 | Condition flag |
| trap | output | 1 | Illegal-instruction pulse |

## Verification
Two things can meet in one cycle: the divider's final step with its writeback, and a new issue request arriving on that same edge. The bench holds a single-cycle add on `issue_valid` for the whole length of a divide. It then checks that the first `done` is the quotient for the divide's destination, exactly 32 cycles after the divide was accepted. The add must finish one cycle later with its own index and sum, and nothing may complete in between.

// File: rtl/iexu_pkg.sv
package iexu_pkg;
  localparam int XLEN = 32;
  localparam int IDXW = 5;
  localparam int SHW  = $clog2(XLEN);

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_MUL,
    OP_SLL, OP_SRL, OP_SRA, OP_ROR, OP_HIGH
  } alu_op_e;

  typedef enum logic [2:0] {K_NONE, K_ALU, K_CMP, K_DIV, K_BAD} kind_e;

  typedef struct packed {
    kind_e           kind;
    alu_op_e         op;
    logic [3:0]      cmp;
    logic            div_signed;
    logic            use_imm;
    logic [XLEN-1:0] imm;
    logic [IDXW-1:0] rd;
  } dec_t;

  function automatic logic [XLEN-1:0] ext16(input logic [15:0] v, input logic signed_ext);
    return signed_ext ? {{(XLEN-16){v[15]}}, v} : {{(XLEN-16){1'b0}}, v};
  endfunction

  function automatic logic [XLEN-1:0] shift_f(input alu_op_e op, input logic [XLEN-1:0] a,
                                              input logic [SHW-1:0] n);
    logic [2*XLEN-1:0] dbl;
    dbl = {a, a} >> n;
    case (op)
      OP_SLL:  return a << n;
      OP_SRL:  return a >> n;
      OP_SRA:  return $unsigned($signed(a) >>> n);
      default: return dbl[XLEN-1:0];
    endcase
  endfunction

  function automatic logic cmp_f(input logic [3:0] sel, input logic [XLEN-1:0] a,
                                 input logic [XLEN-1:0] b);
    case (sel)
      4'd0:    return a == b;
      4'd1:    return a != b;
      4'd2:    return a > b;
      4'd3:    return a >= b;
      4'd4:    return a < b;
      4'd5:    return a <= b;
      4'd6:    return $signed(a) > $signed(b);
      4'd7:    return $signed(a) >= $signed(b);
      4'd8:    return $signed(a) < $signed(b);
      default: return $signed(a) <= $signed(b);
    endcase
  endfunction
endpackage

// File: rtl/iexu_decode.sv
module iexu_decode
  import iexu_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  logic [1:0]  cls;
  logic [3:0]  sub;
  logic [15:0] imm16;
  logic [2:0]  shk;
  logic        shk_ok;
  alu_op_e     shop;

  assign cls   = instr[31:30];
  assign sub   = instr[29:26];
  assign imm16 = instr[15:0];
  assign shk   = instr[7:5];

  always_comb begin
    shk_ok = 1'b1;
    case (shk)
      3'd0:    shop = OP_SLL;
      3'd1:    shop = OP_SRL;
      3'd2:    shop = OP_SRA;
      3'd4:    shop = OP_ROR;
      default: begin shop = OP_SLL; shk_ok = 1'b0; end
    endcase
  end

  always_comb begin
    dec            = '0;
    dec.kind       = K_BAD;
    dec.op         = OP_ADD;
    dec.rd         = instr[25:21];
    dec.cmp        = instr[24:21];
    case (cls)
      2'd0: if (sub == 4'd6) begin
        dec.kind    = K_ALU;
        dec.op      = OP_HIGH;
        dec.use_imm = 1'b1;
        dec.imm     = {imm16, 16'h0};
      end
      2'd2: begin
        dec.use_imm = 1'b1;
        case (sub)
          4'd5:  begin dec.kind = K_ALU; dec.op = OP_ADD; dec.imm = ext16(imm16, 1'b1); end
          4'd7:  begin dec.kind = K_ALU; dec.op = OP_SUB; dec.imm = ext16(imm16, 1'b1); end
          4'd8:  begin dec.kind = K_ALU; dec.op = OP_AND; dec.imm = ext16(imm16, 1'b0); end
          4'd9:  begin dec.kind = K_ALU; dec.op = OP_OR;  dec.imm = ext16(imm16, 1'b0); end
          4'd10: begin dec.kind = K_ALU; dec.op = OP_XOR; dec.imm = ext16(imm16, 1'b0); end
          4'd11: begin dec.kind = K_ALU; dec.op = OP_MUL; dec.imm = ext16(imm16, 1'b0); end
          4'd13: if (shk_ok) begin
            dec.kind = K_ALU;
            dec.op   = shop;
            dec.imm  = {{(XLEN-5){1'b0}}, instr[4:0]};
          end
          4'd14: if (instr[25:21] <= 5'd9) begin
            dec.kind = K_CMP;
            dec.imm  = ext16(imm16, 1'b1);
          end
          default: ;
        endcase
      end
      2'd3: begin
        if (sub == 4'd8) begin
          case (instr[3:0])
            4'd0:  begin dec.kind = K_ALU; dec.op = OP_ADD; end
            4'd2:  begin dec.kind = K_ALU; dec.op = OP_SUB; end
            4'd3:  begin dec.kind = K_ALU; dec.op = OP_AND; end
            4'd4:  begin dec.kind = K_ALU; dec.op = OP_OR;  end
            4'd5:  begin dec.kind = K_ALU; dec.op = OP_XOR; end
            4'd6:  begin dec.kind = K_ALU; dec.op = OP_MUL; end
            4'd8:  if (shk_ok) begin dec.kind = K_ALU; dec.op = shop; end
            4'd9:  begin dec.kind = K_DIV; dec.div_signed = 1'b1; end
            4'd10: begin dec.kind = K_DIV; dec.div_signed = 1'b0; end
            default: ;
          endcase
        end else if (sub == 4'd9 && instr[25:21] <= 5'd9) begin
          dec.kind = K_CMP;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/iexu_alu.sv
module iexu_alu
  import iexu_pkg::*;
#(
  parameter int W = XLEN
) (
  input  dec_t         dec,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] result,
  output logic         cmp_out
);
  logic [W-1:0]   b;
  logic [2*W-1:0] prod;

  assign b    = dec.use_imm ? dec.imm : opb;
  assign prod = opa * b;

  always_comb begin
    case (dec.op)
      OP_ADD:  result = opa + b;
      OP_SUB:  result = opa - b;
      OP_AND:  result = opa & b;
      OP_OR:   result = opa | b;
      OP_XOR:  result = opa ^ b;
      OP_MUL:  result = prod[W-1:0];
      OP_HIGH: result = b;
      default: result = shift_f(dec.op, opa, b[SHW-1:0]);
    endcase
  end

  assign cmp_out = cmp_f(dec.cmp, opa, b);
endmodule

// File: rtl/iexu_divider.sv
module iexu_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         sgn,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] quot
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  rem_q, quo_q, dsr_q;
  logic [W-1:0]  rem_n, quo_n;
  logic [W:0]    trial, diff;
  logic [CW-1:0] cnt_q;
  logic          neg_q, active_q;
  logic [W-1:0]  abs_a, abs_b;

  assign abs_a = (sgn && dividend[W-1]) ? W'(0) - dividend : dividend;
  assign abs_b = (sgn && divisor[W-1])  ? W'(0) - divisor  : divisor;

  assign trial = {rem_q, quo_q[W-1]};
  assign diff  = trial - {1'b0, dsr_q};
  assign rem_n = diff[W] ? trial[W-1:0] : diff[W-1:0];
  assign quo_n = {quo_q[W-2:0], ~diff[W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      rem_q    <= '0;
      quo_q    <= '0;
      dsr_q    <= '0;
      neg_q    <= 1'b0;
    end else if (start && !active_q) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      rem_q    <= '0;
      quo_q    <= abs_a;
      dsr_q    <= abs_b;
      neg_q    <= sgn & (dividend[W-1] ^ divisor[W-1]);
    end else if (active_q) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) active_q <= 1'b0;
    end
  end

  assign busy = active_q;
  assign fin  = active_q && (cnt_q == LAST);
  assign quot = neg_q ? W'(0) - quo_n : quo_n;

  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R7
  fin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy);
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [31:0]     instr,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  output logic            busy,
  output logic            done,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [W-1:0]    wr_data,
  output logic            flag,
  output logic            trap
);
  dec_t            dec;
  logic [W-1:0]    alu_res, div_q;
  logic            cmp_res, div_busy, div_fin;
  logic            accept, div_start, div_zero;
  logic [IDXW-1:0] div_rd_q;

  iexu_decode u_dec (.instr(instr), .dec(dec));

  iexu_alu #(.W(W)) u_alu (
    .dec(dec), .opa(opa), .opb(opb), .result(alu_res), .cmp_out(cmp_res)
  );

  assign accept    = issue_valid && !div_busy;
  assign div_start = accept && dec.kind == K_DIV && opb != '0;
  assign div_zero  = accept && dec.kind == K_DIV && opb == '0;

  iexu_divider #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .sgn(dec.div_signed),
    .dividend(opa), .divisor(opb), .busy(div_busy), .fin(div_fin), .quot(div_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      flag     <= 1'b0;
      trap     <= 1'b0;
      div_rd_q <= '0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      trap  <= 1'b0;
      if (div_fin) begin
        done    <= 1'b1;
        wr_en   <= div_rd_q != '0;
        wr_idx  <= div_rd_q;
        wr_data <= div_q;
      end else if (div_start) begin
        div_rd_q <= dec.rd;
      end else if (accept) begin
        done   <= 1'b1;
        wr_idx <= dec.rd;
        case (dec.kind)
          K_ALU: begin
            wr_en   <= dec.rd != '0;
            wr_data <= alu_res;
          end
          K_CMP:   flag <= cmp_res;
          default: trap <= 1'b1;
        endcase
      end
    end
  end

  assign busy = div_busy;

  // R8
  trap_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (!wr_en && done));
  // R9
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != '0));
  // R11
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7
  busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && !trap));
  // R5
  flag_only_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag != $past(flag)) |-> (done && !wr_en && !trap));
endmodule

// File: tb/test_int_exec_unit.sv
`timescale 1ns/1ps
module test_int_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [31:0] instr = '0, opa = '0, opb = '0;
  logic        busy, done, wr_en, flag, trap;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  int_exec_unit i_int_exec_unit (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
    .opa(opa), .opb(opb), .busy(busy), .done(done), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .flag(flag), .trap(trap)
  );

  function automatic logic [31:0] enc(input logic [1:0] c, input logic [3:0] s,
                                      input logic [4:0] r, input logic [15:0] i);
    return {c, s, r, 5'd0, i};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    issue_valid = 1'b1; instr = ins; opa = a; opb = b;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic expect_wr(input string req, input logic [4:0] r, input logic [31:0] d);
    chk({req, " done"}, 32'(done), 32'd1);
    chk({req, " wr_en"}, 32'(wr_en), 32'd1);
    chk({req, " idx"}, 32'(wr_idx), 32'(r));
    chk({req, " data"}, wr_data, d);
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 wr_en", 32'(wr_en), 0);
    chk("R1 trap", 32'(trap), 0);
    chk("R1 flag", 32'(flag), 0);
  endtask

  task automatic t_regops();
    issue(enc(3, 8, 3, 16'd0), 32'd5, 32'd7);            expect_wr("R2 add", 3, 32'd12);
    issue(enc(3, 8, 4, 16'd2), 32'd3, 32'd10);           expect_wr("R2 sub", 4, 32'd3 - 32'd10);
    issue(enc(3, 8, 5, 16'd3), 32'hF0F0, 32'h0FF0);      expect_wr("R2 and", 5, 32'h00F0);
    issue(enc(3, 8, 6, 16'd4), 32'hF000, 32'h000F);      expect_wr("R2 or", 6, 32'hF00F);
    issue(enc(3, 8, 7, 16'd5), 32'hFFFF0000, 32'h0F0F0F0F); expect_wr("R2 xor", 7, 32'hF0F00F0F);
    issue(enc(3, 8, 8, 16'd6), 32'h00010000, 32'h00010001); expect_wr("R2 mul", 8, 32'h00010000);
  endtask

  task automatic t_immops();
    issue(enc(2, 5, 9, 16'hFFFF), 32'd10, 32'd0);        expect_wr("R3 addi sext", 9, 32'd9);
    issue(enc(2, 7, 9, 16'hFFFE), 32'd10, 32'd0);        expect_wr("R3 subi sext", 9, 32'd12);
    issue(enc(2, 8, 9, 16'hFFFF), 32'hFFFFFFFF, 32'd0);  expect_wr("R3 andi zext", 9, 32'h0000FFFF);
    issue(enc(2, 10, 9, 16'h8000), 32'h0, 32'd0);        expect_wr("R3 xori zext", 9, 32'h00008000);
    issue(enc(2, 11, 9, 16'hFFFF), 32'd2, 32'd0);        expect_wr("R3 muli zext", 9, 32'h0001FFFE);
  endtask

  task automatic t_shift();
    issue(enc(3, 8, 10, {8'd0, 3'd0, 1'b0, 4'd8}), 32'h0000_00F1, 32'd4);
    expect_wr("R4 sll reg", 10, 32'h0000_0F10);
    issue(enc(3, 8, 10, {8'd0, 3'd1, 1'b0, 4'd8}), 32'h8000_0000, 32'd31);
    expect_wr("R4 srl reg", 10, 32'h1);
    issue(enc(2, 13, 11, {8'd0, 3'd2, 5'd31}), 32'h8000_0000, 32'd0);
    expect_wr("R4 sra imm", 11, 32'hFFFF_FFFF);
    issue(enc(2, 13, 11, {8'd0, 3'd4, 5'd8}), 32'h1234_5678, 32'd0);
    expect_wr("R4 ror imm", 11, 32'h7812_3456);
  endtask

  task automatic t_cmp();
    issue(enc(3, 9, 5'd2, 16'd0), 32'hFFFF_FFFF, 32'd1);
    chk("R5 ugt flag", 32'(flag), 1);
    chk("R5 no write", 32'(wr_en), 0);
    chk("R5 done", 32'(done), 1);
    issue(enc(3, 9, 5'd6, 16'd0), 32'hFFFF_FFFF, 32'd1);
    chk("R5 sgt flag", 32'(flag), 0);
    issue(enc(2, 14, 5'd0, 16'hFFFF), 32'hFFFF_FFFF, 32'd0);
    chk("R5 eqi sext flag", 32'(flag), 1);
    issue(enc(3, 8, 12, 16'd0), 32'd1, 32'd1);
    chk("R12 flag held by add", 32'(flag), 1);
    issue(enc(3, 9, 5'd8, 16'd0), 32'd5, 32'd9);
    chk("R5 slt flag", 32'(flag), 1);
    issue(enc(3, 9, 5'd1, 16'd0), 32'd5, 32'd5);
    chk("R5 ne flag", 32'(flag), 0);
    issue(enc(2, 13, 12, {8'd0, 3'd0, 5'd1}), 32'd1, 32'd0);
    chk("R12 flag held by shift", 32'(flag), 0);
  endtask

  task automatic t_movhi();
    issue(enc(0, 6, 13, 16'hBEEF), 32'h1111_1111, 32'd0);
    expect_wr("R6 movhi", 13, 32'hBEEF_0000);
  endtask

  task automatic run_div(input string req, input logic [3:0] code, input logic [4:0] r,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] q);
    int n = 0;
    issue(enc(3, 8, r, {12'd0, code}), a, b);
    chk({req, " busy"}, 32'(busy), 1);
    while (!done && n < 40) begin @(negedge clk); n++; end
    chk({req, " latency"}, n, 32);
    chk({req, " busy low"}, 32'(busy), 0);
    expect_wr(req, r, q);
  endtask

  task automatic t_div();
    run_div("R7 udiv", 4'd10, 14, 32'd100, 32'd7, 32'd14);
    run_div("R7 sdiv neg", 4'd9, 14, -32'sd7, 32'd2, -32'sd3);
    run_div("R7 sdiv negdiv", 4'd9, 15, 32'd7, -32'sd2, -32'sd3);
    run_div("R7 sdiv min", 4'd9, 15, 32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000);
  endtask

  task automatic t_divzero();
    issue(enc(3, 8, 16, 16'd9), 32'd55, 32'd0);
    chk("R8 trap", 32'(trap), 1);
    chk("R8 no write", 32'(wr_en), 0);
    chk("R8 busy", 32'(busy), 0);
    chk("R8 done", 32'(done), 1);
  endtask

  task automatic t_r0();
    issue(enc(3, 8, 0, 16'd0), 32'd1, 32'd2);
    chk("R9 done", 32'(done), 1);
    chk("R9 no write", 32'(wr_en), 0);
  endtask

  task automatic t_illegal();
    logic f0;
    f0 = flag;
    issue(enc(1, 0, 3, 16'd0), 32'd1, 32'd1);
    chk("R10 class1 trap", 32'(trap), 1);
    chk("R10 class1 no write", 32'(wr_en), 0);
    issue(enc(3, 8, 3, 16'd1), 32'd1, 32'd1);
    chk("R10 low4=1 trap", 32'(trap), 1);
    issue(enc(2, 13, 3, {8'd0, 3'd3, 5'd1}), 32'd1, 32'd1);
    chk("R10 shift kind3 trap", 32'(trap), 1);
    issue(enc(3, 9, 5'd12, 16'd0), 32'd1, 32'd1);
    chk("R10 cmp sel12 trap", 32'(trap), 1);
    chk("R10 flag unchanged", 32'(flag), 32'(f0));
  endtask

  task automatic t_busy_issue();
    int n = 0;
    issue(enc(3, 8, 17, 16'd10), 32'd1000, 32'd10);
    issue_valid = 1'b1; instr = enc(3, 8, 18, 16'd0); opa = 32'd1; opb = 32'd2;
    while (!done && n < 40) begin @(negedge clk); n++; end
    chk("R11 div first", n, 32);
    expect_wr("R11 div result", 17, 32'd100);
    @(negedge clk);
    issue_valid = 1'b0;
    expect_wr("R11 held add accepted", 18, 32'd3);
    @(negedge clk);
    chk("R11 single completion", 32'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_regops();
    t_immops();
    t_shift();
    t_cmp();
    t_movhi();
    t_div();
    t_divzero();
    t_r0();
    t_illegal();
    t_busy_issue();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule